// File: doc/BRIEF.md
# E1 Sa-bit capture buffer

This block gathers the five national spare bits, Sa4 through Sa8, from an E1 receive stream. It watches timeslot 0 of every odd-numbered frame within the 16-frame multiframe and writes each spare bit into a shadow byte for its Sa position. There is one byte per position, and the bit index inside the byte follows the frame number. At each multiframe boundary all five shadow bytes move together into a read bank. That bank then holds still for a whole multiframe, which gives a processor 2 ms to read it before the contents change.

Framing is supplied from outside. A framer provides a per-bit enable, the frame number (0 to 15, where frame 0 is the one that starts at the boundary), the timeslot number and the bit position within the timeslot. Bit position 0 is the first bit transmitted. The framer also strobes the multiframe start on the first bit of frame 0. A mode input selects T1, and a flag reports loss of frame alignment. Under either condition the captured data has no meaning, so the block drops its valid output, clears the partly built shadow and withholds the next transfer. After alignment returns, a whole multiframe must be captured before the next transfer.

Top module: `e1_sa_capture`

## Requirements
- R1: A spare bit is taken only on a cycle with `bit_en` high, `ts_num` = 0, an odd `frame_num`, E1 mode and alignment held, and `bit_pos` in 3..7. Positions 3, 4, 5, 6 and 7 carry Sa4, Sa5, Sa6, Sa7 and Sa8. Bits in even frames, in other timeslots, at positions 0..2 or on cycles with `bit_en` low never reach the read bank.
- R2: After a transfer, `sa_bank[8*k+n]` holds the Sa(4+k) bit received in frame 2n+1 of the multiframe just completed. Lane k = 0 is Sa4 and lane 4 is Sa8.
- R3: `sa_bank` changes only on the clock edge of a transfer. It is stable at every other time, including the whole multiframe that follows a transfer.
- R4: A transfer happens at the rising edge where `mf_start` is high, provided E1 mode and alignment hold in that cycle and a complete multiframe has been captured since the previous aligned boundary. All five bytes load at that same edge.
- R5: `mf_irq` is high for exactly one cycle per transfer, and that cycle is the one in which the new `sa_bank` contents first appear. It never pulses without a transfer.
- R6: `sa_valid` is low in every cycle where `t1_mode` or `align_lost` is high, with no delay.
- R7: Any cycle with `t1_mode` or `align_lost` high clears the shadow bytes and cancels the pending transfer. The first aligned boundary after that only starts a capture, and the boundary after it transfers.
- R8: `sa_valid` rises together with the first transfer after reset or after loss of alignment. It stays high until `t1_mode` or `align_lost` is raised.
- R9: While `rst_n` is low, `sa_bank` reads zero and `sa_valid` and `mf_irq` are low. The reset is asynchronous on assertion and synchronous on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| rx_bit | input | 1 | Receive data bit |
| bit_en | input | 1 | Qualifies rx_bit and the timing strobes for this cycle |
| frame_num | input | 4 | Frame number within the multiframe, 0..15 |
| ts_num | input | 5 | Timeslot number, 0..31 |
| bit_pos | input | 3 | Bit position in the timeslot, 0 = first transmitted |
| mf_start | input | 1 | One-cycle strobe on the first bit of frame 0 |
| t1_mode | input | 1 | High selects T1 operation, which makes the data meaningless |
| align_lost | input | 1 | Receiver reports loss of frame alignment |
| sa_bank | output | 40 | Read bank, five 8-bit lanes, Sa4 in bits 7..0 |
| sa_valid | output | 1 | Read bank holds meaningful data |
| mf_irq | output | 1 | One-cycle pulse on each read-bank update |

## Verification
Two functions can land on the same clock edge: the multiframe transfer, and the clear that loss of alignment forces. The bench provokes this by raising `align_lost` for exactly the cycle in which `mf_start` is strobed, at a point where a complete multiframe is already waiting in the shadow. The clear must win. The bench then expects no `mf_irq`, an unchanged `sa_bank` and `sa_valid` low. At the following boundary it expects only a new capture to begin, and at the boundary after that a transfer carrying the new data.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int unsigned SA_LANES     = 5;   // Sa4..Sa8
  localparam int unsigned MF_FRAMES    = 16;  // frames per multiframe
  localparam int unsigned SA_FIRST_POS = 3;   // bit_pos carrying Sa4
  localparam int unsigned TS_WIDTH     = 5;
  localparam int unsigned POS_WIDTH    = 3;
endpackage

// File: rtl/e1_sa_tap.sv
// Decodes the framer strobes into one write enable per Sa lane plus the
// slot index (odd frame number divided by two).
module e1_sa_tap
  import e1_sa_pkg::*;
#(
  parameter int unsigned NUM_SA    = SA_LANES,
  parameter int unsigned FRAMES    = MF_FRAMES,
  parameter int unsigned FIRST_POS = SA_FIRST_POS,
  localparam int unsigned FW = $clog2(FRAMES),
  localparam int unsigned SW = FW - 1
) (
  input  logic                 bit_en,
  input  logic                 in_sync,
  input  logic [FW-1:0]        frame_num,
  input  logic [TS_WIDTH-1:0]  ts_num,
  input  logic [POS_WIDTH-1:0] bit_pos,
  output logic [NUM_SA-1:0]    lane_we,
  output logic [SW-1:0]        slot
);

  logic odd_ts0_hit;

  always_comb begin
    odd_ts0_hit = bit_en & in_sync & (ts_num == '0) & frame_num[0];
    slot        = frame_num[FW-1:1];
  end

  for (genvar k = 0; k < NUM_SA; k++) begin : g_lane_dec
    assign lane_we[k] = odd_ts0_hit & (bit_pos == POS_WIDTH'(FIRST_POS + k));
  end

endmodule

// File: rtl/e1_sa_shadow.sv
// Shadow bytes, one per Sa lane, written slot by slot during the multiframe.
module e1_sa_shadow #(
  parameter int unsigned NUM_SA = 5,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_sync,
  input  logic                    rx_bit,
  input  logic [NUM_SA-1:0]       lane_we,
  input  logic [SW-1:0]           slot,
  output logic [NUM_SA*SLOTS-1:0] shadow
);

  for (genvar g = 0; g < NUM_SA; g++) begin : g_shadow
    logic [SLOTS-1:0] byte_q;
    logic [SLOTS-1:0] byte_d;
    logic             byte_en;

    always_comb begin
      byte_en = ~in_sync | lane_we[g];
      byte_d  = byte_q;
      byte_d[slot] = rx_bit;
      if (!in_sync) begin
        byte_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end

    assign shadow[g*SLOTS +: SLOTS] = byte_q;
  end

endmodule

// File: rtl/e1_sa_ctrl.sv
// Boundary sequencing: arm on an aligned boundary, transfer on the next one,
// interrupt pulse and valid flag.
module e1_sa_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_start,
  input  logic in_sync,
  output logic xfer,
  output logic irq,
  output logic valid
);

  logic armed_q, armed_d;
  logic loaded_q, loaded_d;
  logic irq_q;

  always_comb begin
    xfer     = mf_start & in_sync & armed_q;
    armed_d  = armed_q;
    loaded_d = loaded_q;
    if (!in_sync) begin
      armed_d  = 1'b0;
      loaded_d = 1'b0;
    end else begin
      if (mf_start) armed_d  = 1'b1;
      if (xfer)     loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      loaded_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      loaded_q <= loaded_d;
      irq_q    <= xfer;
    end
  end

  assign irq   = irq_q;
  assign valid = loaded_q & in_sync;

endmodule

// File: rtl/e1_sa_bank.sv
// Processor-visible read bank, loaded from the shadow on transfer only.
module e1_sa_bank #(
  parameter int unsigned WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic [WIDTH-1:0] shadow,
  output logic [WIDTH-1:0] bank
);

  logic [WIDTH-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (xfer) begin
      bank_q <= shadow;
    end
  end

  assign bank = bank_q;

endmodule

// File: rtl/e1_sa_capture.sv
module e1_sa_capture
  import e1_sa_pkg::*;
#(
  parameter int unsigned NUM_SA    = SA_LANES,
  parameter int unsigned FRAMES    = MF_FRAMES,
  parameter int unsigned FIRST_POS = SA_FIRST_POS,
  localparam int unsigned SLOTS  = FRAMES / 2,
  localparam int unsigned FW     = $clog2(FRAMES),
  localparam int unsigned SW     = FW - 1,
  localparam int unsigned BANK_W = NUM_SA * SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_bit,
  input  logic                 bit_en,
  input  logic [FW-1:0]        frame_num,
  input  logic [TS_WIDTH-1:0]  ts_num,
  input  logic [POS_WIDTH-1:0] bit_pos,
  input  logic                 mf_start,
  input  logic                 t1_mode,
  input  logic                 align_lost,
  output logic [BANK_W-1:0]    sa_bank,
  output logic                 sa_valid,
  output logic                 mf_irq
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic              in_sync;
  logic [NUM_SA-1:0] lane_we;
  logic [SW-1:0]     slot;
  logic [BANK_W-1:0] shadow;
  logic              xfer;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  assign in_sync = ~t1_mode & ~align_lost;

  e1_sa_tap #(
    .NUM_SA   (NUM_SA),
    .FRAMES   (FRAMES),
    .FIRST_POS(FIRST_POS)
  ) u_tap (
    .bit_en   (bit_en),
    .in_sync  (in_sync),
    .frame_num(frame_num),
    .ts_num   (ts_num),
    .bit_pos  (bit_pos),
    .lane_we  (lane_we),
    .slot     (slot)
  );

  e1_sa_shadow #(
    .NUM_SA(NUM_SA),
    .SLOTS (SLOTS)
  ) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .in_sync(in_sync),
    .rx_bit (rx_bit),
    .lane_we(lane_we),
    .slot   (slot),
    .shadow (shadow)
  );

  e1_sa_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .mf_start(mf_start),
    .in_sync (in_sync),
    .xfer    (xfer),
    .irq     (mf_irq),
    .valid   (sa_valid)
  );

  e1_sa_bank #(
    .WIDTH(BANK_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n_int),
    .xfer  (xfer),
    .shadow(shadow),
    .bank  (sa_bank)
  );

endmodule

// File: rtl/e1_sa_capture_chk.sv
module e1_sa_capture_chk #(
  parameter int unsigned BANK_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mf_start,
  input logic              t1_mode,
  input logic              align_lost,
  input logic [BANK_W-1:0] sa_bank,
  input logic              sa_valid,
  input logic              mf_irq
);

  // R3: the bank moves only in an interrupt cycle
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_irq |-> $stable(sa_bank));

  // R5: interrupt is a single-cycle pulse
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    mf_irq |=> !mf_irq);

  // R4: an interrupt follows an aligned E1 boundary strobe
  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mf_irq |-> ($past(mf_start) && !$past(align_lost) && !$past(t1_mode)));

  // R6: valid is gated off while the data is meaningless
  a_r6_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_mode || align_lost) |-> !sa_valid);

  // R8: a fresh load in aligned E1 mode shows valid
  a_r8_valid_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_irq && !align_lost && !t1_mode) |-> sa_valid);

endmodule

bind e1_sa_capture e1_sa_capture_chk #(.BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .mf_start  (mf_start),
  .t1_mode   (t1_mode),
  .align_lost(align_lost),
  .sa_bank   (sa_bank),
  .sa_valid  (sa_valid),
  .mf_irq    (mf_irq)
);

// File: tb/tb_e1_sa_capture.sv
module tb_e1_sa_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rx_bit;
  logic        bit_en;
  logic [3:0]  frame_num;
  logic [4:0]  ts_num;
  logic [2:0]  bit_pos;
  logic        mf_start;
  logic        t1_mode;
  logic        align_lost;
  logic [39:0] sa_bank;
  logic        sa_valid;
  logic        mf_irq;

  int n_chk;
  int n_bad;
  int irq_cnt;
  bit done;

  logic [39:0]      exp_bank;
  bit               exp_loaded;
  bit               prev_full;
  logic [4:0][15:0] prev_sa;

  e1_sa_capture dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit    (rx_bit),
    .bit_en    (bit_en),
    .frame_num (frame_num),
    .ts_num    (ts_num),
    .bit_pos   (bit_pos),
    .mf_start  (mf_start),
    .t1_mode   (t1_mode),
    .align_lost(align_lost),
    .sa_bank   (sa_bank),
    .sa_valid  (sa_valid),
    .mf_irq    (mf_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && mf_irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 packing: lane k bit n <- Sa(4+k) of frame 2n+1
  function automatic logic [39:0] pack_bank(input logic [4:0][15:0] sa);
    logic [39:0] r;
    for (int k = 0; k < 5; k++)
      for (int n = 0; n < 8; n++)
        r[k*8 + n] = sa[k][2*n + 1];
    return r;
  endfunction

  function automatic logic [4:0][15:0] rand_sa();
    logic [4:0][15:0] s;
    for (int k = 0; k < 5; k++) s[k] = 16'($urandom);
    return s;
  endfunction

  // One multiframe. bad_frame >= 1 marks a frame run with t1 or
  // misalignment; bad_bnd raises align_lost only in the boundary cycle.
  task automatic run_mf(input logic [4:0][15:0] sa, input int bad_frame,
                        input bit bad_t1, input bit bad_bnd, input string btag);
    bit xfer_exp;
    int irq0;
    bit cur_bad;
    irq0     = irq_cnt;
    xfer_exp = !bad_bnd && prev_full;
    for (int f = 0; f < 16; f++) begin
      cur_bad = (f == bad_frame);
      for (int ts = 0; ts < 3; ts++) begin
        for (int b = 0; b < 8; b++) begin
          if (!(f == 0 && ts == 0 && b <= 1) && ($urandom % 6 == 0)) begin
            // decoy idle cycle: looks like an Sa slot but bit_en is low (R1)
            @(negedge clk);
            bit_en    = 1'b0;
            mf_start  = 1'b0;
            frame_num = 4'(f | 1);
            ts_num    = 5'd0;
            bit_pos   = 3'(3 + $urandom % 5);
            rx_bit    = 1'($urandom);
          end
          @(negedge clk);
          if (f == 0 && ts == 0 && b == 1) begin
            chk(mf_irq == xfer_exp, xfer_exp ? "R4/R5 irq" : "R7 irq",
                64'(mf_irq), 64'(xfer_exp));
            if (xfer_exp) begin
              exp_bank   = pack_bank(prev_sa);
              exp_loaded = 1'b1;
            end
            if (bad_bnd) exp_loaded = 1'b0;
            chk(sa_bank == exp_bank, btag, 64'(sa_bank), 64'(exp_bank));
            chk(sa_valid == exp_loaded, "R8 valid", 64'(sa_valid), 64'(exp_loaded));
          end
          if (ts == 1 && b == 0) begin
            chk(sa_bank == exp_bank, "R3 hold", 64'(sa_bank), 64'(exp_bank));
            if (cur_bad) begin
              chk(sa_valid == 1'b0, "R6 valid", 64'(sa_valid), 64'd0);
              exp_loaded = 1'b0;
            end else begin
              chk(sa_valid == exp_loaded, "R8 valid", 64'(sa_valid), 64'(exp_loaded));
            end
          end
          bit_en     = 1'b1;
          frame_num  = 4'(f);
          ts_num     = 5'(ts);
          bit_pos    = 3'(b);
          mf_start   = (f == 0 && ts == 0 && b == 0);
          align_lost = (cur_bad && !bad_t1) || (bad_bnd && f == 0 && ts == 0 && b == 0);
          t1_mode    = cur_bad && bad_t1;
          if (ts == 0 && (f % 2) == 1) begin
            if (b == 1)      rx_bit = 1'b1;
            else if (b >= 3) rx_bit = sa[b-3][f];
            else             rx_bit = 1'($urandom);
          end else begin
            rx_bit = 1'($urandom);
          end
        end
      end
    end
    @(negedge clk);
    align_lost = 1'b0;
    t1_mode    = 1'b0;
    chk(irq_cnt - irq0 == int'(xfer_exp), "R5 pulse count",
        64'(irq_cnt - irq0), 64'(xfer_exp));
    prev_sa   = sa;
    prev_full = !bad_bnd && (bad_frame < 0);
  endtask

  initial begin
    logic [4:0][15:0] s;
    void'($urandom(32'h5A17));
    n_chk = 0; n_bad = 0; irq_cnt = 0; done = 0;
    rst_n = 1'b0; rx_bit = 1'b0; bit_en = 1'b0; frame_num = '0; ts_num = '0;
    bit_pos = '0; mf_start = 1'b0; t1_mode = 1'b0; align_lost = 1'b0;
    exp_bank = '0; exp_loaded = 1'b0; prev_full = 1'b0; prev_sa = '0;
    repeat (4) @(negedge clk);
    chk(sa_bank == '0, "R9 bank", 64'(sa_bank), 64'd0);
    chk(sa_valid == 1'b0, "R9 valid", 64'(sa_valid), 64'd0);
    chk(mf_irq == 1'b0, "R9 irq", 64'(mf_irq), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // first boundary only arms (R7)
    run_mf(rand_sa(), -1, 0, 0, "R7 first");
    // directed: odd frames all ones, even frames zero (R1)
    for (int k = 0; k < 5; k++) s[k] = 16'hAAAA;
    run_mf(s, -1, 0, 0, "R2 random");
    // directed: odd frames zero, even frames one -> expect 0xFF bytes next
    for (int k = 0; k < 5; k++) s[k] = 16'h5555;
    run_mf(s, -1, 0, 0, "R1 all-ones");
    // directed: lane k set only in frame 2k+1
    for (int k = 0; k < 5; k++) s[k] = 16'(1 << (2*k + 1));
    run_mf(s, -1, 0, 0, "R1 even-frames-ignored");
    for (int i = 0; i < 6; i++) begin
      run_mf(rand_sa(), -1, 0, 0, (i == 0) ? "R2 walking" : "R2 random");
    end
    // misalignment inside a multiframe
    run_mf(rand_sa(), 7, 0, 0, "R2 random");
    run_mf(rand_sa(), -1, 0, 0, "R7 after loss");
    run_mf(rand_sa(), -1, 0, 0, "R7 rearm");
    // T1 mode inside a multiframe
    run_mf(rand_sa(), 3, 1, 0, "R2 random");
    run_mf(rand_sa(), -1, 0, 0, "R7 after t1");
    run_mf(rand_sa(), -1, 0, 0, "R7 rearm");
    // loss of alignment on the boundary cycle itself
    run_mf(rand_sa(), -1, 0, 1, "R7 boundary clash");
    run_mf(rand_sa(), -1, 0, 0, "R7 after clash");
    for (int i = 0; i < 4; i++) begin
      run_mf(rand_sa(), -1, 0, 0, "R2 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule